// File: doc/BRIEF.md
# Cascode Switch Drive Sequencer

This block orders the on/off drive lines of a two-device series power switch: a clamp switch that diverts the load current, the series switch in the emitter or cathode path, three base-drive legs (a strong start pulse, a proportional boost drive and a lower proportional steady drive), and a switch that diverts base current during turn-off. It also enables or disables the low-voltage detector. Stage changes follow events rather than fixed delays. The switch voltage falling below the low-voltage threshold ends the start pulse. A peak-recovery detect pulse starts the move from boost drive to steady drive. Only the minimum times and the detector re-arm delay are counted, all in clock cycles.

A normal turn-on goes through start, boost, a re-arm wait and steady drive. If the switch voltage is slightly negative when the command arrives, the antiparallel diode is conducting. The controller then waits for the voltage to rise above the threshold and runs a start-pulse turn-on that never uses the boost leg. Minimum on and off times hold back, but never discard, a command that comes too early. A fault input forces the switch off and keeps it off. Every change between the clamp and the series switch passes through one cycle where all outputs are low.

Top module: `cascode_drive_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no command, clamp_sw and divert_sw are 1 and series_sw, start_drv, boost_drv, steady_drv and lowdet_en are 0.
- R2: With the off time satisfied and sw_neg low, a high cmd_on gives one cycle with every output 0. In the next cycle series_sw, start_drv, boost_drv and lowdet_en go to 1.
- R3: When sw_low is 1 in the start stage, start_drv goes to 0 on the next cycle while boost_drv stays 1.
- R4: When rec_det is 1 in the boost stage, lowdet_en goes to 0 for RECOV_ARM_CYC+1 cycles. During that window sw_low is ignored and boost_drv stays 1. Afterwards lowdet_en returns to 1.
- R5: When sw_low is 1 with the detector re-armed after recovery, boost_drv goes to 0 and steady_drv goes to 1 on the next cycle.
- R6: A low cmd_on in any on stage, once allowed, gives one cycle with every output 0. After that only clamp_sw and divert_sw are 1.
- R7: series_sw stays 1 for at least MIN_ON_CYC cycles. An early turn-off request is carried out once that time has elapsed, so the on time is then exactly MIN_ON_CYC cycles.
- R8: clamp_sw stays 1 for at least MIN_OFF_CYC cycles after turn-off. A turn-on request that is held during this time is carried out when the time expires.
- R9: If sw_neg is 1 when a turn-on is accepted, the outputs keep the off pattern with lowdet_en set to 1 until sw_low is 0. Then come one all-zero cycle and a stage with series_sw and start_drv at 1. boost_drv never rises. sw_low then moves the switch to steady drive.
- R10: If fault_in is 1 in any on stage, the turn-off sequence starts at the next clock edge, even inside the minimum on time. While fault_in stays 1, no turn-on begins.
- R11: clamp_sw and series_sw are never 1 together. series_sw only rises one cycle after clamp_sw was 0.
- R12: rec_det has no effect outside the boost stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_on | input | 1 | Switch command, 1 = on |
| sw_low | input | 1 | Switch voltage below the low threshold |
| sw_neg | input | 1 | Switch voltage slightly negative (diode conducting) |
| rec_det | input | 1 | Peak reverse-recovery detect pulse |
| fault_in | input | 1 | Latched fault, forces off |
| clamp_sw | output | 1 | Clamp switch drive |
| series_sw | output | 1 | Emitter/cathode series switch drive |
| start_drv | output | 1 | Start-pulse base drive |
| boost_drv | output | 1 | Boost proportional base drive |
| steady_drv | output | 1 | Steady proportional base drive |
| divert_sw | output | 1 | Base-current diverting switch |
| lowdet_en | output | 1 | Low-voltage detector enable |

## Verification
The bench drives a full boost turn-on while sw_low stays high through the re-arm window. A controller that did not gate the detector would jump to steady drive too early. It sends turn-off and turn-on requests inside the minimum times and measures the run lengths. A controller that dropped a request would hang in one state, and one that skipped the timer would give runs that are too short. A turn-on is made with the diode conducting, which checks that the boost leg never rises. A fault arrives inside the minimum on time, which catches a design that waits for the timer or that turns on again while the fault is held. A cycle-level model compares all seven outputs on every clock, so any missing gap cycle shows up at once.

// File: rtl/cds_pkg.sv
package cds_pkg;

  typedef enum logic [3:0] {
    ST_OFF    = 4'd0,
    ST_REVW   = 4'd1,
    ST_GON    = 4'd2,
    ST_GNB    = 4'd3,
    ST_START  = 4'd4,
    ST_BOOST  = 4'd5,
    ST_REARM  = 4'd6,
    ST_WLV    = 4'd7,
    ST_STEADY = 4'd8,
    ST_NBST   = 4'd9,
    ST_GOFF   = 4'd10
  } cds_state_e;

  typedef struct packed {
    logic clamp;
    logic divert;
    logic series;
    logic start;
    logic boost;
    logic steady;
    logic arm;
  } cds_drv_t;

  function automatic logic cds_is_on(cds_state_e s);
    return (s == ST_START) || (s == ST_BOOST) || (s == ST_REARM) ||
           (s == ST_WLV) || (s == ST_STEADY) || (s == ST_NBST);
  endfunction

endpackage

// File: rtl/cds_timer.sv
module cds_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = val;
    else      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && val != '0) |=> !done); // R7

endmodule

// File: rtl/cds_fsm.sv
module cds_fsm
  import cds_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_on,
  input  logic       sw_low,
  input  logic       sw_neg,
  input  logic       rec_det,
  input  logic       fault_in,
  input  logic       on_done,
  input  logic       off_done,
  input  logic       arm_done,
  output cds_state_e state_q,
  output logic       on_load,
  output logic       off_load,
  output logic       arm_load
);

  cds_state_e state_d;
  logic       leave_on;

  assign leave_on = fault_in || (!cmd_on && on_done);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF: begin
        if (!fault_in && cmd_on && off_done)
          state_d = sw_neg ? ST_REVW : ST_GON;
      end
      ST_REVW: begin
        if (fault_in || !cmd_on) state_d = ST_OFF;
        else if (!sw_low)        state_d = ST_GNB;
      end
      ST_GON:  state_d = fault_in ? ST_GOFF : ST_START;
      ST_GNB:  state_d = fault_in ? ST_GOFF : ST_NBST;
      ST_START: begin
        if (leave_on)    state_d = ST_GOFF;
        else if (sw_low) state_d = ST_BOOST;
      end
      ST_BOOST: begin
        if (leave_on)     state_d = ST_GOFF;
        else if (rec_det) state_d = ST_REARM;
      end
      ST_REARM: begin
        if (leave_on)      state_d = ST_GOFF;
        else if (arm_done) state_d = ST_WLV;
      end
      ST_WLV, ST_NBST: begin
        if (leave_on)    state_d = ST_GOFF;
        else if (sw_low) state_d = ST_STEADY;
      end
      ST_STEADY: begin
        if (leave_on) state_d = ST_GOFF;
      end
      ST_GOFF: state_d = ST_OFF;
      default: state_d = ST_GOFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign on_load  = ((state_d == ST_GON) || (state_d == ST_GNB)) &&
                    (state_q != ST_GON) && (state_q != ST_GNB);
  assign off_load = (state_d == ST_GOFF) && (state_q != ST_GOFF);
  assign arm_load = (state_q == ST_BOOST) && (state_d == ST_REARM);

  AST_START_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && sw_low) |=> (state_q != ST_START)); // R3
  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_in && cds_is_on(state_q)) |=> (state_q == ST_GOFF)); // R10
  AST_REARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REARM && !arm_done && !fault_in && cmd_on) |=> (state_q == ST_REARM)); // R4
  AST_REC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STEADY && rec_det && !fault_in && cmd_on) |=> (state_q == ST_STEADY)); // R12

endmodule

// File: rtl/cds_outdec.sv
module cds_outdec
  import cds_pkg::*;
(
  input  cds_state_e state,
  output cds_drv_t   drv
);

  always_comb begin
    drv = '0;
    unique case (state)
      ST_OFF:    begin drv.clamp = 1'b1; drv.divert = 1'b1; end
      ST_REVW:   begin drv.clamp = 1'b1; drv.divert = 1'b1; drv.arm = 1'b1; end
      ST_START:  begin drv.series = 1'b1; drv.start = 1'b1; drv.boost = 1'b1; drv.arm = 1'b1; end
      ST_BOOST:  begin drv.series = 1'b1; drv.boost = 1'b1; drv.arm = 1'b1; end
      ST_REARM:  begin drv.series = 1'b1; drv.boost = 1'b1; end
      ST_WLV:    begin drv.series = 1'b1; drv.boost = 1'b1; drv.arm = 1'b1; end
      ST_STEADY: begin drv.series = 1'b1; drv.steady = 1'b1; end
      ST_NBST:   begin drv.series = 1'b1; drv.start = 1'b1; drv.arm = 1'b1; end
      default:   drv = '0;
    endcase
  end

endmodule

// File: rtl/cascode_drive_seq.sv
module cascode_drive_seq
  import cds_pkg::*;
#(
  parameter int MIN_ON_CYC    = 63,
  parameter int MIN_OFF_CYC   = 325,
  parameter int RECOV_ARM_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_on,
  input  logic sw_low,
  input  logic sw_neg,
  input  logic rec_det,
  input  logic fault_in,
  output logic clamp_sw,
  output logic series_sw,
  output logic start_drv,
  output logic boost_drv,
  output logic steady_drv,
  output logic divert_sw,
  output logic lowdet_en
);

  localparam int ON_W  = $clog2(MIN_ON_CYC + 1);
  localparam int OFF_W = $clog2(MIN_OFF_CYC + 1);
  localparam int ARM_W = $clog2(RECOV_ARM_CYC + 1);

  cds_state_e state;
  cds_drv_t   drv;
  logic on_load, off_load, arm_load;
  logic on_done, off_done, arm_done;

  cds_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .sw_low(sw_low),
    .sw_neg(sw_neg), .rec_det(rec_det), .fault_in(fault_in),
    .on_done(on_done), .off_done(off_done), .arm_done(arm_done),
    .state_q(state), .on_load(on_load), .off_load(off_load), .arm_load(arm_load)
  );

  cds_timer #(.W(ON_W)) u_on_tmr (
    .clk(clk), .rst_n(rst_n), .load(on_load),
    .val(ON_W'(MIN_ON_CYC)), .done(on_done)
  );

  cds_timer #(.W(OFF_W)) u_off_tmr (
    .clk(clk), .rst_n(rst_n), .load(off_load),
    .val(OFF_W'(MIN_OFF_CYC)), .done(off_done)
  );

  cds_timer #(.W(ARM_W)) u_arm_tmr (
    .clk(clk), .rst_n(rst_n), .load(arm_load),
    .val(ARM_W'(RECOV_ARM_CYC)), .done(arm_done)
  );

  cds_outdec u_dec (.state(state), .drv(drv));

  assign clamp_sw   = drv.clamp;
  assign divert_sw  = drv.divert;
  assign series_sw  = drv.series;
  assign start_drv  = drv.start;
  assign boost_drv  = drv.boost;
  assign steady_drv = drv.steady;
  assign lowdet_en  = drv.arm;

  logic [15:0] on_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          on_run_q <= '0;
    else if (!series_sw)                 on_run_q <= '0;
    else if (on_run_q != 16'hFFFF)       on_run_q <= on_run_q + 16'd1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(clamp_sw && series_sw)); // R11
  AST_GAP_BEFORE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(series_sw) |-> !$past(clamp_sw)); // R11
  AST_MIN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(series_sw) && !$past(fault_in)) |-> (on_run_q >= 16'(MIN_ON_CYC))); // R7
  AST_FAULT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_in && !series_sw) |=> !series_sw); // R10

endmodule

// File: tb/cascode_drive_seq_tb.sv
module cascode_drive_seq_tb;

  localparam int MON  = 63;
  localparam int MOFF = 325;
  localparam int MARM = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_on = 1'b0, sw_low = 1'b0, sw_neg = 1'b0, rec_det = 1'b0, fault_in = 1'b0;
  logic clamp_sw, series_sw, start_drv, boost_drv, steady_drv, divert_sw, lowdet_en;

  always #4 clk = ~clk;

  cascode_drive_seq #(.MIN_ON_CYC(MON), .MIN_OFF_CYC(MOFF), .RECOV_ARM_CYC(MARM)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .sw_low(sw_low), .sw_neg(sw_neg),
    .rec_det(rec_det), .fault_in(fault_in), .clamp_sw(clamp_sw), .series_sw(series_sw),
    .start_drv(start_drv), .boost_drv(boost_drv), .steady_drv(steady_drv),
    .divert_sw(divert_sw), .lowdet_en(lowdet_en)
  );

  int    n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit    done_flag = 0;

  // Behavioural reference: mode names as integers, remaining-time counters
  int m_mode = 0;     // 0 off,1 wait-rise,2 gap-on,3 gap-nb,4 start,5 boost,6 rearm,7 wait-low,8 steady,9 nb-start,10 gap-off
  int m_on = 0, m_off = 0, m_arm = 0;

  function automatic logic [6:0] expect_bits(int m);
    // {clamp, divert, series, start, boost, steady, arm}
    case (m)
      0: return 7'b1100000;
      1: return 7'b1100001;
      4: return 7'b0011101;
      5: return 7'b0010101;
      6: return 7'b0010100;
      7: return 7'b0010101;
      8: return 7'b0010010;
      9: return 7'b0011001;
      default: return 7'b0000000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_on = 0; m_off = 0; m_arm = 0;
    end else begin
      int nxt;
      bit is_on, quit;
      nxt = m_mode;
      is_on = (m_mode >= 4 && m_mode <= 9);
      quit = fault_in || (!cmd_on && m_on == 0);
      if (m_mode == 0) begin
        if (!fault_in && cmd_on && m_off == 0) nxt = sw_neg ? 1 : 2;
      end else if (m_mode == 1) begin
        if (fault_in || !cmd_on) nxt = 0; else if (!sw_low) nxt = 3;
      end else if (m_mode == 2) nxt = fault_in ? 10 : 4;
      else if (m_mode == 3) nxt = fault_in ? 10 : 9;
      else if (m_mode == 10) nxt = 0;
      else if (is_on && quit) nxt = 10;
      else if (m_mode == 4 && sw_low) nxt = 5;
      else if (m_mode == 5 && rec_det) nxt = 6;
      else if (m_mode == 6 && m_arm == 0) nxt = 7;
      else if ((m_mode == 7 || m_mode == 9) && sw_low) nxt = 8;
      if (m_on > 0) m_on--;
      if (m_off > 0) m_off--;
      if (m_arm > 0) m_arm--;
      if ((nxt == 2 || nxt == 3) && m_mode != 2 && m_mode != 3) m_on = MON;
      if (nxt == 10 && m_mode != 10) m_off = MOFF;
      if (m_mode == 5 && nxt == 6) m_arm = MARM;
      m_mode = nxt;
    end
  end

  int ser_run = 0, last_ser = 0, clp_run = 0, last_clp = 0;
  bit nb_phase = 0, nb_boost_seen = 0;

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      logic [6:0] act, exp_v;
      act = {clamp_sw, divert_sw, series_sw, start_drv, boost_drv, steady_drv, lowdet_en};
      exp_v = expect_bits(m_mode);
      n_chk++;
      if (act !== exp_v) begin
        n_bad++;
        $display("FAIL %s cycle compare: actual %b expected %b", cur_req, act, exp_v);
      end
      if (series_sw) ser_run++; else if (ser_run > 0) begin last_ser = ser_run; ser_run = 0; end
      if (clamp_sw) clp_run++; else if (clp_run > 0) begin last_clp = clp_run; clp_run = 0; end
      if (nb_phase && boost_drv) nb_boost_seen = 1;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  task automatic wait_clamp(int lim);
    for (int i = 0; i < lim && !clamp_sw; i++) step(1);
  endtask

  task automatic wait_series(int lim);
    for (int i = 0; i < lim && !series_sw; i++) step(1);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    step(1);
    chk(clamp_sw && divert_sw && !series_sw && !lowdet_en, "R1", "in reset", int'(series_sw), 0);
    step(3);
    rst_n = 1'b1;
    step(2);
    chk(clamp_sw && divert_sw && !series_sw && !start_drv && !boost_drv && !steady_drv,
        "R1", "after reset clamp", int'(clamp_sw), 1);

    // boost turn-on path
    cur_req = "R2";
    cmd_on = 1'b1;
    step(1);
    chk(!clamp_sw && !series_sw, "R11", "gap before on", int'(clamp_sw | series_sw), 0);
    step(1);
    chk(series_sw && start_drv && boost_drv && lowdet_en, "R2", "start stage", int'(start_drv), 1);
    step(4);
    cur_req = "R3";
    sw_low = 1'b1;
    step(2);
    chk(!start_drv && boost_drv, "R3", "start removed", int'(start_drv), 0);
    step(2);
    cur_req = "R4";
    rec_det = 1'b1; step(1); rec_det = 1'b0;
    chk(!lowdet_en && boost_drv, "R4", "detector off after recovery", int'(lowdet_en), 0);
    step(MARM - 2);
    chk(boost_drv && !steady_drv, "R4", "low flag ignored while disarmed", int'(steady_drv), 0);
    cur_req = "R5";
    step(4);
    chk(steady_drv && !boost_drv && series_sw, "R5", "steady drive", int'(steady_drv), 1);
    cur_req = "R12";
    rec_det = 1'b1; step(1); rec_det = 1'b0;
    step(2);
    chk(steady_drv && !boost_drv && lowdet_en == 1'b0, "R12", "recovery ignored", int'(boost_drv), 0);

    // early turn-off deferred
    cur_req = "R7";
    cmd_on = 1'b0;
    step(2);
    chk(series_sw, "R7", "off request deferred", int'(series_sw), 1);
    wait_clamp(200);
    chk(last_ser == MON, "R7", "on run length", last_ser, MON);
    cur_req = "R6";
    chk(clamp_sw && divert_sw && !series_sw && !steady_drv, "R6", "off pattern", int'(clamp_sw), 1);

    // early turn-on deferred
    cur_req = "R8";
    sw_low = 1'b0;
    cmd_on = 1'b1;
    step(5);
    chk(clamp_sw && !series_sw, "R8", "on request deferred", int'(series_sw), 0);
    wait_series(MOFF + 50);
    chk(last_clp == MOFF, "R8", "off run length", last_clp, MOFF);
    cmd_on = 1'b0;
    wait_clamp(200);
    step(MOFF + 5);

    // diode-conducting turn-on
    cur_req = "R9";
    sw_neg = 1'b1; sw_low = 1'b1; cmd_on = 1'b1;
    nb_phase = 1;
    step(3);
    chk(clamp_sw && lowdet_en && !series_sw, "R9", "waiting for rise", int'(series_sw), 0);
    step(8);
    sw_neg = 1'b0; sw_low = 1'b0;
    step(1);
    chk(!clamp_sw && !series_sw, "R9", "gap before no-boost on", int'(clamp_sw), 0);
    step(1);
    chk(series_sw && start_drv && !boost_drv, "R9", "no-boost start", int'(boost_drv), 0);
    step(3);
    sw_low = 1'b1;
    step(2);
    chk(steady_drv && !start_drv, "R9", "steady after no-boost start", int'(steady_drv), 1);
    cmd_on = 1'b0;
    wait_clamp(200);
    nb_phase = 0;
    chk(!nb_boost_seen, "R9", "boost never raised", int'(nb_boost_seen), 0);
    step(MOFF + 5);

    // fault
    cur_req = "R10";
    sw_low = 1'b0; cmd_on = 1'b1;
    step(4);
    chk(series_sw, "R10", "on before fault", int'(series_sw), 1);
    fault_in = 1'b1;
    step(1);
    chk(!series_sw && !clamp_sw, "R10", "forced off gap", int'(series_sw), 0);
    step(1);
    chk(clamp_sw && divert_sw, "R10", "forced off clamp", int'(clamp_sw), 1);
    step(MOFF + 10);
    chk(clamp_sw && !series_sw, "R10", "turn-on blocked", int'(series_sw), 0);
    fault_in = 1'b0;
    step(3);
    chk(series_sw && !clamp_sw, "R10", "on after fault clears", int'(series_sw), 1);
    cmd_on = 1'b0;
    wait_clamp(200);
    step(4);

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule